// File: doc/BRIEF.md
# Code-Density Calibrated Timestamp Unit

This block turns the fine code of a delay-line time measurement into a calibrated time. It does not assume that every code spans the same delay. A calibration run first collects a programmed number of hits, which must be a power of two. The hits come from events that are random with respect to the clock. The block keeps a histogram of how often each fine code appears. It then makes one sequential pass over the codes. In that pass it gives each code a width equal to its share of hits, scaled to one coarse clock period, and accumulates the widths into a characteristic curve. That curve maps every code to a time.

In measurement mode each valid fine code reads the curve directly instead of being multiplied by a fixed step. The curve value is combined with a coarse clock count into an unsigned timestamp with 1 ps resolution, in the form `(coarse + 1) * T - curve[code]`. Subtracting a START timestamp from a STOP timestamp therefore gives the coarse count difference times the period, plus the fine START time, minus the fine STOP time. With the default 8-bit coarse count and a 2400 ps period, the range covers 256 × 2.4 ns = 614.4 ns. An upstream bubble corrector can disable codes through a mask, and disabled codes add nothing to the curve.

Top module: `cd_timestamp_unit`

## Requirements
- R1: After reset, `ready_o` is 1 and `cal_done_o` and `ts_valid_o` are 0. Every curve entry is 0, so a measurement returns `(coarse + 1) * CLK_PS`.
- R2: A `cal_start_i` pulse while `ready_o` is 1 does the following at that edge: it clears all histogram counts, latches `hits_log2_i` as n (clamped to `MAX_LOG2`), and drops `ready_o` and `cal_done_o`. The next 2^n cycles with `code_valid_i` high are hits, and each hit adds one to the count of its code.
- R3: The edge that takes the 2^n-th hit starts the curve pass. `ready_o` then stays 0 for exactly `2^CODE_W` cycles and returns to 1 in the same cycle in which `cal_done_o` becomes 1.
- R4: The width of code k is floor(count_k × `CLK_PS` / 2^n). The width is 0 when the code got no hits or when bit k of `code_mask_i` is 1 during the pass.
- R5: Curve entry k is the sum of the widths of codes 0 to k, using the floored widths.
- R6: A histogram count stops at 2^`HIST_W` − 1 and never wraps.
- R7: When `code_valid_i` is 1 and `ready_o` is 1, then in the next cycle `ts_valid_o` is 1 and `ts_o` = (`coarse_i` + 1) × `CLK_PS` − curve[`code_i`]. Otherwise `ts_valid_o` is 0 in that next cycle.
- R8: While `ready_o` is 0, `code_valid_i` produces no timestamp. Codes that arrive during the curve pass are not counted as hits.
- R9: For two timestamps, STOP minus START equals (coarse_stop − coarse_start) × `CLK_PS` + curve[code_start] − curve[code_stop].
- R10: A `cal_start_i` pulse while `ready_o` is 0 is ignored. Counts gathered so far are kept, and the run still ends after 2^n hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_start_i | input | 1 | Start a calibration run |
| hits_log2_i | input | SH_W | log2 of the number of calibration hits |
| code_mask_i | input | 2^CODE_W | Per-code disable; a set bit gives that code zero width |
| code_valid_i | input | 1 | Fine code strobe: a hit while calibrating, a timestamp request while ready |
| code_i | input | CODE_W | Fine code |
| coarse_i | input | COARSE_W | Coarse clock count for the request |
| ready_o | output | 1 | Measurement mode; requests are accepted |
| cal_done_o | output | 1 | A curve has been built since the last start |
| ts_valid_o | output | 1 | Timestamp valid |
| ts_o | output | TS_W | Timestamp in ps |

## Verification
Each calibration drives a skewed code distribution. One code never occurs and one code is masked. Every code is then read back at the lowest and highest coarse counts. A design that divides by the wrong shift, or that floors the running sum instead of each width, drifts away from the expected curve. A masked or absent code that is not zeroed shows up as a step between two neighbouring entries that should be equal. A run that sends every hit to one code pushes its count past 16 bits. A wrapping counter would then give that code zero width instead of 2399 ps. Requests made during the curve pass and a restart made during collection are checked for having no effect. A design that accepted them would emit stray timestamps, count extra hits, or end the run at the wrong hit.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_BUILD   = 2'd2
  } tsu_state_e;
endpackage

// File: rtl/tsu_hist.sv
module tsu_hist #(
  parameter int CODE_W = 8,
  parameter int HIST_W = 16,
  localparam int NCODES = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] rd_idx_i,
  output logic [HIST_W-1:0] rd_cnt_o
);
  logic [HIST_W-1:0] cnt_q [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_bin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
      end else if (clr_i) begin
        cnt_q[g] <= '0;
      end else if (inc_i && code_i == CODE_W'(g) && cnt_q[g] != '1) begin
        cnt_q[g] <= cnt_q[g] + HIST_W'(1);  // saturating
      end
    end
  end

  assign rd_cnt_o = cnt_q[rd_idx_i];
endmodule

// File: rtl/tsu_curve.sv
module tsu_curve #(
  parameter int CODE_W = 8,
  parameter int HIST_W = 16,
  parameter int CLK_PS = 2400,
  parameter int SH_W   = 5,
  localparam int NCODES = 1 << CODE_W,
  localparam int CLK_W  = $clog2(CLK_PS + 1),
  localparam int FINE_W = CLK_W,
  localparam int PROD_W = HIST_W + CLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic [NCODES-1:0] mask_i,
  output logic [CODE_W-1:0] rd_idx_o,
  input  logic [HIST_W-1:0] rd_cnt_i,
  output logic              last_o,
  input  logic [CODE_W-1:0] lk_code_i,
  output logic [FINE_W-1:0] lk_val_o
);
  logic              busy_q;
  logic [CODE_W-1:0] idx_q;
  logic [FINE_W-1:0] acc_q;
  logic [PROD_W-1:0] prod_w;
  logic [PROD_W-1:0] scaled_w;
  logic [FINE_W-1:0] width_w;
  logic [FINE_W-1:0] sum_w;
  logic [FINE_W-1:0] curve_q [NCODES];

  // floored widths sum to at most one period, so FINE_W never overflows
  assign prod_w   = PROD_W'(rd_cnt_i) * PROD_W'(CLK_PS);
  assign scaled_w = prod_w >> shift_i;
  assign width_w  = mask_i[idx_q] ? '0 : FINE_W'(scaled_w);
  assign sum_w    = acc_q + width_w;
  assign rd_idx_o = idx_q;
  assign last_o   = busy_q && (idx_q == CODE_W'(NCODES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      acc_q  <= '0;
    end else if (busy_q) begin
      acc_q <= sum_w;
      idx_q <= idx_q + CODE_W'(1);
      if (last_o) busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCODES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        curve_q[g] <= '0;
      end else if (busy_q && idx_q == CODE_W'(g)) begin
        curve_q[g] <= sum_w;
      end
    end
  end

  assign lk_val_o = curve_q[lk_code_i];
endmodule

// File: rtl/tsu_stamp.sv
module tsu_stamp #(
  parameter int COARSE_W = 8,
  parameter int FINE_W   = 12,
  parameter int CLK_PS   = 2400,
  parameter int TS_W     = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic                valid_o,
  output logic [TS_W-1:0]     ts_o
);
  logic [TS_W-1:0] base_w;

  // end of the coarse cycle minus the calibrated fine time
  assign base_w = (TS_W'(coarse_i) + TS_W'(1)) * TS_W'(CLK_PS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ts_o    <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) ts_o <= base_w - TS_W'(fine_i);
    end
  end
endmodule

// File: rtl/cd_timestamp_unit.sv
module cd_timestamp_unit
  import tsu_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int COARSE_W = 8,
  parameter int CLK_PS   = 2400,
  parameter int HIST_W   = 16,
  parameter int MAX_LOG2 = 20,
  localparam int NCODES  = 1 << CODE_W,
  localparam int SH_W    = $clog2(MAX_LOG2 + 1),
  localparam int HCNT_W  = MAX_LOG2 + 1,
  localparam int FINE_W  = $clog2(CLK_PS + 1),
  localparam int TS_W    = $clog2(((1 << COARSE_W) + 1) * CLK_PS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cal_start_i,
  input  logic [SH_W-1:0]     hits_log2_i,
  input  logic [NCODES-1:0]   code_mask_i,
  input  logic                code_valid_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [COARSE_W-1:0] coarse_i,
  output logic                ready_o,
  output logic                cal_done_o,
  output logic                ts_valid_o,
  output logic [TS_W-1:0]     ts_o
);
  tsu_state_e        state_q;
  logic [SH_W-1:0]   shift_q;
  logic [HCNT_W-1:0] hit_cnt_q;
  logic [HCNT_W-1:0] target_w;
  logic              start_ok_w;
  logic              hit_w;
  logic              bld_start_w;
  logic              bld_last_w;
  logic [CODE_W-1:0] rd_idx_w;
  logic [HIST_W-1:0] rd_cnt_w;
  logic [FINE_W-1:0] fine_w;

  assign ready_o     = (state_q == ST_IDLE);
  assign start_ok_w  = cal_start_i && ready_o;
  assign hit_w       = code_valid_i && (state_q == ST_COLLECT);
  assign target_w    = HCNT_W'(1) << shift_q;
  assign bld_start_w = hit_w && ((hit_cnt_q + HCNT_W'(1)) == target_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      shift_q    <= '0;
      hit_cnt_q  <= '0;
      cal_done_o <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_ok_w) begin
          state_q    <= ST_COLLECT;
          hit_cnt_q  <= '0;
          cal_done_o <= 1'b0;
          shift_q    <= (hits_log2_i > SH_W'(MAX_LOG2)) ? SH_W'(MAX_LOG2) : hits_log2_i;
        end
        ST_COLLECT: if (hit_w) begin
          hit_cnt_q <= hit_cnt_q + HCNT_W'(1);
          if (bld_start_w) state_q <= ST_BUILD;
        end
        ST_BUILD: if (bld_last_w) begin
          state_q    <= ST_IDLE;
          cal_done_o <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  tsu_hist #(.CODE_W(CODE_W), .HIST_W(HIST_W)) i_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok_w),
    .inc_i    (hit_w),
    .code_i   (code_i),
    .rd_idx_i (rd_idx_w),
    .rd_cnt_o (rd_cnt_w)
  );

  tsu_curve #(.CODE_W(CODE_W), .HIST_W(HIST_W), .CLK_PS(CLK_PS), .SH_W(SH_W)) i_curve (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (bld_start_w),
    .shift_i   (shift_q),
    .mask_i    (code_mask_i),
    .rd_idx_o  (rd_idx_w),
    .rd_cnt_i  (rd_cnt_w),
    .last_o    (bld_last_w),
    .lk_code_i (code_i),
    .lk_val_o  (fine_w)
  );

  tsu_stamp #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .CLK_PS(CLK_PS), .TS_W(TS_W)) i_stamp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (code_valid_i && ready_o),
    .coarse_i (coarse_i),
    .fine_i   (fine_w),
    .valid_o  (ts_valid_o),
    .ts_o     (ts_o)
  );
endmodule

// File: rtl/cd_timestamp_unit_chk.sv
module cd_timestamp_unit_chk #(
  parameter int COARSE_W = 8,
  parameter int CLK_PS   = 2400,
  parameter int TS_W     = 20
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cal_start_i,
  input logic                code_valid_i,
  input logic [COARSE_W-1:0] coarse_i,
  input logic                ready_o,
  input logic                cal_done_o,
  input logic                ts_valid_o,
  input logic [TS_W-1:0]     ts_o
);
  a_r7_ts_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_i && ready_o |=> ts_valid_o);

  a_r8_no_ts_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(code_valid_i && ready_o) |=> !ts_valid_o);

  a_r7_ts_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_i && ready_o |=>
      (longint'(ts_o) >= longint'(CLK_PS) * longint'($past(coarse_i))) &&
      (longint'(ts_o) <= longint'(CLK_PS) * (longint'($past(coarse_i)) + 1)));

  a_r2_start_leaves_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_i && ready_o |=> !ready_o && !cal_done_o);

  a_r3_done_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_done_o) |-> ready_o && $past(!ready_o));

  a_r3_done_implies_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |-> ready_o);
endmodule

bind cd_timestamp_unit cd_timestamp_unit_chk #(
  .COARSE_W(COARSE_W), .CLK_PS(CLK_PS), .TS_W(TS_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cal_start_i  (cal_start_i),
  .code_valid_i (code_valid_i),
  .coarse_i     (coarse_i),
  .ready_o      (ready_o),
  .cal_done_o   (cal_done_o),
  .ts_valid_o   (ts_valid_o),
  .ts_o         (ts_o)
);

// File: tb/test_cd_timestamp_unit.sv
module test_cd_timestamp_unit;
  localparam int CLK_NS   = 10;
  localparam int CODE_W   = 4;
  localparam int NC       = 1 << CODE_W;
  localparam int COARSE_W = 8;
  localparam int CLK_PS   = 2400;
  localparam int HIST_W   = 16;
  localparam int MAX_LOG2 = 16;
  localparam int SH_W     = $clog2(MAX_LOG2 + 1);
  localparam int TS_W     = $clog2(((1 << COARSE_W) + 1) * CLK_PS + 1);

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                cal_start_i = 1'b0;
  logic [SH_W-1:0]     hits_log2_i = '0;
  logic [NC-1:0]       code_mask_i = '0;
  logic                code_valid_i = 1'b0;
  logic [CODE_W-1:0]   code_i = '0;
  logic [COARSE_W-1:0] coarse_i = '0;
  logic                ready_o, cal_done_o, ts_valid_o;
  logic [TS_W-1:0]     ts_o;

  int     n_chk = 0;
  int     n_err = 0;
  longint cnt_exp [NC];
  longint curve_exp [NC];

  always #(CLK_NS / 2) clk_i = ~clk_i;

  cd_timestamp_unit #(
    .CODE_W(CODE_W), .COARSE_W(COARSE_W), .CLK_PS(CLK_PS),
    .HIST_W(HIST_W), .MAX_LOG2(MAX_LOG2)
  ) i_cd_timestamp_unit (.*);

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(int code, int coarse, output longint ts);
    @(negedge clk_i);
    code_valid_i = 1'b1; code_i = CODE_W'(code); coarse_i = COARSE_W'(coarse);
    @(negedge clk_i);
    code_valid_i = 1'b0;
    chk("R7 ts_valid", longint'(ts_valid_o), 1);
    ts = longint'(ts_o);
  endtask

  function automatic int gen_code(int mode, int i);
    case (mode)
      0: return ((i * i) + (i >> 2)) % 15;  // code 15 never hit
      1: return (i % 4 == 0) ? 2 : (i % 4 == 1) ? 11 : (i * 3) % 16;
      default: return 3;
    endcase
  endfunction

  task automatic calibrate(int n, int mode, logic [NC-1:0] mask);
    int low_cycles = 0;
    longint acc = 0;
    for (int k = 0; k < NC; k++) cnt_exp[k] = 0;
    code_mask_i = mask;
    hits_log2_i = SH_W'(n);
    @(negedge clk_i);
    cal_start_i = 1'b1;
    @(negedge clk_i);
    cal_start_i = 1'b0;
    chk("R2 ready low", longint'(ready_o), 0);
    chk("R2 done cleared", longint'(cal_done_o), 0);
    for (int i = 0; i < (1 << n); i++) begin
      int c = gen_code(mode, i);
      cnt_exp[c]++;
      code_valid_i = 1'b1;
      code_i = CODE_W'(c);
      coarse_i = COARSE_W'(i);
      cal_start_i = (mode == 1 && i == 5);  // R10: restart mid-run ignored
      @(negedge clk_i);
      if (ts_valid_o) chk("R8 no ts while collecting", 1, 0);
    end
    cal_start_i = 1'b0;
    // keep requesting during the pass: none may count or stamp (R8)
    code_valid_i = 1'b1; code_i = CODE_W'(NC - 1);
    while (!ready_o && low_cycles < 4 * NC) begin
      if (ts_valid_o) chk("R8 no ts during pass", 1, 0);
      low_cycles++;
      @(negedge clk_i);
    end
    code_valid_i = 1'b0;
    chk("R3 pass length", low_cycles, NC);
    chk("R3 done with ready", longint'(cal_done_o), 1);
    for (int k = 0; k < NC; k++) begin
      longint c = (cnt_exp[k] > 65535) ? 65535 : cnt_exp[k];  // R6
      longint w = mask[k] ? 0 : ((c * CLK_PS) >> n);           // R4
      acc += w;
      curve_exp[k] = acc;                                      // R5
    end
  endtask

  task automatic check_curve(string tag);
    longint ts;
    for (int k = 0; k < NC; k++) begin
      measure(k, 0, ts);
      chk({tag, " R5 R7 coarse0"}, ts, CLK_PS - curve_exp[k]);
      measure(k, 255, ts);
      chk({tag, " R5 R7 coarse255"}, ts, 256 * CLK_PS - curve_exp[k]);
    end
  endtask

  task automatic check_interval(int ca, int a, int cb, int b);
    longint t0, t1;
    measure(a, ca, t0);
    measure(b, cb, t1);
    chk("R9 interval", t1 - t0,
        longint'(cb - ca) * CLK_PS + curve_exp[a] - curve_exp[b]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    longint ts, ta, tb;
    repeat (3) @(negedge clk_i);
    chk("R1 ready", longint'(ready_o), 1);
    chk("R1 done", longint'(cal_done_o), 0);
    chk("R1 ts_valid", longint'(ts_valid_o), 0);
    rst_ni = 1'b1;
    measure(5, 3, ts);
    chk("R1 empty curve", ts, 4 * CLK_PS);
    @(negedge clk_i);
    chk("R7 valid drops", longint'(ts_valid_o), 0);

    // run A: skewed spread, code 15 absent, code 9 masked
    calibrate(8, 0, NC'(1 << 9));
    check_curve("A");
    measure(8, 10, ta);
    measure(9, 10, tb);
    chk("R4 masked code flat", ta - tb, 0);
    chk("R4 absent code flat", curve_exp[15] - curve_exp[14], 0);
    measure(15, 0, ts);
    chk("R5 last entry", ts, CLK_PS - curve_exp[14]);
    check_interval(0, 3, 7, 12);
    check_interval(200, 14, 201, 0);
    check_interval(0, 0, 255, 15);

    // run B: new distribution, restart pulse mid-collect
    calibrate(4, 1, '0);
    check_curve("B R10");

    // run C: all hits on one code, count saturates
    calibrate(16, 2, '0);
    chk("R6 expected width", curve_exp[3], 2399);
    measure(3, 0, ts);
    chk("R6 saturated width", ts, 1);
    measure(2, 0, ts);
    chk("R6 codes below", ts, CLK_PS);
    measure(15, 1, ts);
    chk("R6 codes above", ts, 2 * CLK_PS - 2399);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule